// File: doc/BRIEF.md
# Two-Channel Transfer Control and Status Registers

This block is the software-facing register pair of a two-channel data-flow transfer engine. A byte-wide bus port writes a control register and reads either the control register or a status register. The control register holds, for each channel, an interrupt enable, a write-one acknowledge for the end-of-flow flag, and an abort command that hardware clears by itself. The status register shows each channel's live busy, source-ready and destination-ready inputs next to the sticky end-of-flow flag.

On the engine side the block takes per-channel busy, ready and end-of-flow pulse inputs. It returns a one-cycle abort pulse per channel and a single registered interrupt request. The read port is combinational, so a read returns the state of the current cycle. The channel count is a parameter. Each channel owns a four-bit slot in both registers, and channel c starts at bit 4c.

Top module: `xfer_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x00 (with engine inputs low), and the abort outputs and the interrupt output are 0.
- R2: `bus_sel` = 0 selects the control register. In channel c's slot (bits 4c to 4c+3), bit 4c+3 is abort, bit 4c+2 is interrupt enable, bit 4c+1 is acknowledge and bit 4c is reserved. A control write stores the enable bits, which read back as written.
- R3: A control write with bit 4c+3 set drives `eng_abort[c]` high for exactly the following cycle. The control bit reads 1 during that cycle, and both return to 0 after it unless the write is repeated.
- R4: A control write with bit 4c+1 set clears channel c's end-of-flow flag on the next cycle. Writing 0 there leaves the flag unchanged, and the bit always reads 0.
- R5: The reserved control bits (bit 4c) always read 0, even after they are written with 1.
- R6: A pulse on `eng_eof[c]` sets channel c's end-of-flow flag on the next cycle, and the flag then stays set. No bus write to either register can set the flag.
- R7: `bus_sel` = 1 selects the status register. Channel c's slot shows busy at bit 4c, source-ready at 4c+1, destination-ready at 4c+2 and the end-of-flow flag at 4c+3. The first three follow the engine inputs in the same cycle, and writes to this address change nothing.
- R8: When an end-of-flow pulse and an acknowledge for the same channel fall in the same cycle, the flag stays set.
- R9: `irq` is a register that carries, one cycle later, the OR over all channels of (flag AND enable).
- R10: A channel whose enable is 0 does not raise `irq`, even while its flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_sel | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 4*NUM_CH | Write data |
| bus_rdata | output | 4*NUM_CH | Read data of the selected register (combinational) |
| eng_busy | input | NUM_CH | Per-channel transfer in progress |
| eng_src_rdy | input | NUM_CH | Per-channel source peripheral ready |
| eng_dst_rdy | input | NUM_CH | Per-channel destination peripheral ready |
| eng_eof | input | NUM_CH | Per-channel end-of-flow pulse |
| eng_abort | output | NUM_CH | Per-channel one-cycle abort pulse |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The bench builds the block with the default NUM_CH = 2, which gives the full 8-bit layout with two slots. This exercises the cross-channel cases: an acknowledge for one channel must not touch the other channel's flag, and an interrupt enabled on one channel must not pass through the flag of the other. A behavioural model tracks the enables, flags, abort pulses and the delayed interrupt, and it is compared with both register views and the outputs on every clock. Directed sequences then cover the same-cycle event and acknowledge race and the reserved and acknowledge bits that always read 0. A randomized mix of bus writes, selects and engine inputs follows them.

// File: rtl/xfer_regs_pkg.sv
// Shared field positions and types for the transfer control/status registers.
// Assumes a fixed four-bit slot per channel in both registers.
package xfer_regs_pkg;
    localparam int SLOT_W    = 4;
    // Control slot bit positions (relative to the slot base)
    localparam int CTL_RSVD  = 0;
    localparam int CTL_ACK   = 1;
    localparam int CTL_IEN   = 2;
    localparam int CTL_ABORT = 3;
    // Status slot bit positions (relative to the slot base)
    localparam int ST_BUSY   = 0;
    localparam int ST_SRC    = 1;
    localparam int ST_DST    = 2;
    localparam int ST_FLAG   = 3;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic abort;
        logic ien;
        logic flag;
    } chan_state_t;
endpackage

// File: rtl/xfer_chan_slice.sv
// Per-channel control state: enable, sticky end-of-flow flag and abort pulse.
// Assumes ctl_wr is a single-cycle qualified write to the control register and
// wr_slot is this channel's four-bit slice of the write data.
module xfer_chan_slice
    import xfer_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              eof_i,
    output chan_state_t       state_o
);
    logic abort_q;
    logic ien_q;
    logic flag_q;
    logic ack_req;

    assign ack_req = ctl_wr & wr_slot[CTL_ACK];

    // Abort is a command pulse: set by a write, gone the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) abort_q <= 1'b0;
        else        abort_q <= ctl_wr & wr_slot[CTL_ABORT];
    end

    // Interrupt enable follows every control write
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (ctl_wr) ien_q <= wr_slot[CTL_IEN];
    end

    // Sticky flag: event wins over acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= eof_i | (flag_q & ~ack_req);
    end

    assign state_o = '{abort: abort_q, ien: ien_q, flag: flag_q};

    AST_ABORT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_q) |-> $past(ctl_wr && wr_slot[CTL_ABORT])); // R3
    AST_ABORT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_q && !(ctl_wr && wr_slot[CTL_ABORT])) |=> !abort_q); // R3
    AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        eof_i |=> flag_q); // R8
    AST_FLAG_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !eof_i) |=> !flag_q); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && ack_req && !eof_i) |=> !flag_q); // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !ack_req) |=> flag_q); // R6
endmodule

// File: rtl/xfer_irq_merge.sv
// Combines per-channel flag AND enable into one registered interrupt request.
// Assumes flags and enables are registered state from the channel slices.
module xfer_irq_merge #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] flags_i,
    input  logic [NUM_CH-1:0] ien_i,
    output logic              irq_o
);
    logic any_pending;

    // Any enabled channel with a pending flag
    always_comb any_pending = |(flags_i & ien_i);

    // Register the request so irq never glitches
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= any_pending;
    end

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_i & ien_i)) |=> irq_o); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags_i & ien_i) == '0) |=> !irq_o); // R10
endmodule

// File: rtl/xfer_read_mux.sv
// Builds the control and status register images and selects one for reading.
// Assumes a combinational read path; ack and reserved bits are wired to 0.
module xfer_read_mux
    import xfer_regs_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int DW    = SLOT_W * NUM_CH
) (
    input  reg_sel_e          sel_i,
    input  chan_state_t       st_i [NUM_CH],
    input  logic [NUM_CH-1:0] busy_i,
    input  logic [NUM_CH-1:0] src_i,
    input  logic [NUM_CH-1:0] dst_i,
    output logic [DW-1:0]     rdata_o
);
    logic [DW-1:0] ctrl_img;
    logic [DW-1:0] stat_img;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_img
        // Control slot: abort and enable visible, ack and reserved read 0
        always_comb begin
            ctrl_img[c*SLOT_W + CTL_ABORT] = st_i[c].abort;
            ctrl_img[c*SLOT_W + CTL_IEN]   = st_i[c].ien;
            ctrl_img[c*SLOT_W + CTL_ACK]   = 1'b0;
            ctrl_img[c*SLOT_W + CTL_RSVD]  = 1'b0;
        end
        // Status slot: live engine inputs plus the sticky flag
        always_comb begin
            stat_img[c*SLOT_W + ST_BUSY] = busy_i[c];
            stat_img[c*SLOT_W + ST_SRC]  = src_i[c];
            stat_img[c*SLOT_W + ST_DST]  = dst_i[c];
            stat_img[c*SLOT_W + ST_FLAG] = st_i[c].flag;
        end
    end

    // Select the addressed register image
    always_comb rdata_o = (sel_i == SEL_STAT) ? stat_img : ctrl_img;
endmodule

// File: rtl/xfer_ctrl_regs.sv
// Top: control/status register pair for a multi-channel transfer engine.
// Assumes one bus access per cycle; reads are combinational; writes to the
// status address are ignored.
module xfer_ctrl_regs
    import xfer_regs_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int DW    = SLOT_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_CH-1:0] eng_busy,
    input  logic [NUM_CH-1:0] eng_src_rdy,
    input  logic [NUM_CH-1:0] eng_dst_rdy,
    input  logic [NUM_CH-1:0] eng_eof,
    output logic [NUM_CH-1:0] eng_abort,
    output logic              irq
);
    reg_sel_e          sel;
    logic              ctl_wr;
    chan_state_t       ch_st [NUM_CH];
    logic [NUM_CH-1:0] flags;
    logic [NUM_CH-1:0] ienv;

    assign sel    = reg_sel_e'(bus_sel);
    assign ctl_wr = bus_wr & (sel == SEL_CTRL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        xfer_chan_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_wr  (ctl_wr),
            .wr_slot (bus_wdata[c*SLOT_W +: SLOT_W]),
            .eof_i   (eng_eof[c]),
            .state_o (ch_st[c])
        );
        assign eng_abort[c] = ch_st[c].abort;
        assign flags[c]     = ch_st[c].flag;
        assign ienv[c]      = ch_st[c].ien;

        AST_RSVD_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == SEL_CTRL) |-> (bus_rdata[c*SLOT_W + CTL_RSVD] == 1'b0 &&
                                   bus_rdata[c*SLOT_W + CTL_ACK]  == 1'b0)); // R5
        AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == SEL_STAT) |-> (bus_rdata[c*SLOT_W + ST_BUSY] == eng_busy[c])); // R7
    end

    xfer_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags),
        .ien_i   (ienv),
        .irq_o   (irq)
    );

    xfer_read_mux #(.NUM_CH(NUM_CH)) u_rd (
        .sel_i   (sel),
        .st_i    (ch_st),
        .busy_i  (eng_busy),
        .src_i   (eng_src_rdy),
        .dst_i   (eng_dst_rdy),
        .rdata_o (bus_rdata)
    );
endmodule

// File: tb/xfer_ctrl_regs_tb.sv
module xfer_ctrl_regs_tb_top;
    localparam int NUM_CH = 2;
    localparam int DW     = 4 * NUM_CH;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              bus_wr;
    logic              bus_sel;
    logic [DW-1:0]     bus_wdata;
    logic [DW-1:0]     bus_rdata;
    logic [NUM_CH-1:0] eng_busy, eng_src_rdy, eng_dst_rdy, eng_eof, eng_abort;
    logic              irq;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    // reference model state
    bit m_en [NUM_CH];
    bit m_flag [NUM_CH];
    bit m_abort [NUM_CH];
    bit m_irq;

    always #10 clk = ~clk; // 50 MHz

    xfer_ctrl_regs #(.NUM_CH(NUM_CH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
        .eng_src_rdy(eng_src_rdy), .eng_dst_rdy(eng_dst_rdy), .eng_eof(eng_eof),
        .eng_abort(eng_abort), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // model update from the inputs present at the clock edge
    task automatic model_update();
        bit nirq = 0;
        for (int c = 0; c < NUM_CH; c++) nirq |= (m_flag[c] & m_en[c]);
        for (int c = 0; c < NUM_CH; c++) begin
            bit cw = bus_wr && !bus_sel;
            if (!rst_n) begin
                m_en[c] = 0; m_flag[c] = 0; m_abort[c] = 0;
            end else begin
                m_abort[c] = cw && bus_wdata[4*c+3];
                m_flag[c]  = eng_eof[c] || (m_flag[c] && !(cw && bus_wdata[4*c+1]));
                if (cw) m_en[c] = bus_wdata[4*c+2];
            end
        end
        m_irq = rst_n ? nirq : 1'b0;
    endtask

    task automatic compare_all();
        logic [DW-1:0] exp_rd = '0;
        logic [NUM_CH-1:0] exp_ab = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            exp_ab[c] = m_abort[c];
            if (bus_sel) begin
                exp_rd[4*c+0] = eng_busy[c];
                exp_rd[4*c+1] = eng_src_rdy[c];
                exp_rd[4*c+2] = eng_dst_rdy[c];
                exp_rd[4*c+3] = m_flag[c];
            end else begin
                exp_rd[4*c+3] = m_abort[c];
                exp_rd[4*c+2] = m_en[c];
            end
        end
        if (bus_sel) check("R7 status image", 32'(bus_rdata), 32'(exp_rd));
        else         check("R2 control image", 32'(bus_rdata), 32'(exp_rd));
        check("R3 abort pulse", 32'(eng_abort), 32'(exp_ab));
        check("R9 irq", 32'(irq), 32'(m_irq));
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        #2;
        if (rst_n) compare_all();
    endtask

    task automatic idle();
        bus_wr = 0; bus_wdata = '0; eng_eof = '0;
    endtask

    task automatic wr_ctrl(input logic [DW-1:0] v);
        bus_wr = 1; bus_sel = 0; bus_wdata = v;
        tick();
        idle();
    endtask

    task automatic peek(input logic sel, input string tag, input logic [DW-1:0] exp);
        bus_sel = sel;
        #1;
        check(tag, 32'(bus_rdata), 32'(exp));
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_sel = 0; eng_busy = '0; eng_src_rdy = '0; eng_dst_rdy = '0;
        idle();
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        peek(0, "R1 control after reset", 8'h00);
        peek(1, "R1 status after reset", 8'h00);
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 abort after reset", 32'(eng_abort), 0);

        // R2 enables read back
        wr_ctrl(8'h44);
        peek(0, "R2 enable readback", 8'h44);

        // R3 abort pulse, R5 reserved, R4 ack reads 0
        wr_ctrl(8'hFF);
        peek(0, "R3 R5 abort visible, ack and reserved zero", 8'hCC);
        check("R3 abort outputs", 32'(eng_abort), 32'h3);
        tick();
        peek(0, "R3 abort self-cleared", 8'h44);
        check("R3 abort outputs low", 32'(eng_abort), 0);

        // R6 software cannot set flag; R7 status writes ignored
        bus_wr = 1; bus_sel = 1; bus_wdata = 8'hFF; tick(); idle();
        peek(1, "R6 R7 status write ignored", 8'h00);
        peek(0, "R7 control unchanged by status write", 8'h44);

        // R6 event sets flag; R9 irq one cycle later
        eng_eof = 2'b01; tick(); idle();
        peek(1, "R6 flag ch0 set", 8'h08);
        check("R9 irq lags flag", 32'(irq), 0);
        tick();
        check("R9 irq raised", 32'(irq), 1);

        // R4 writing 0 to ack keeps flag; ack of ch1 leaves ch0
        wr_ctrl(8'h64);
        peek(1, "R4 other channel ack no effect", 8'h08);
        wr_ctrl(8'h46);
        peek(1, "R4 ack clears ch0 flag", 8'h00);
        tick();
        check("R9 irq dropped", 32'(irq), 0);

        // R10 disabled channel does not interrupt
        wr_ctrl(8'h04);
        eng_eof = 2'b10; tick(); idle();
        peek(1, "R10 ch1 flag set", 8'h80);
        tick(); tick();
        check("R10 irq stays low", 32'(irq), 0);

        // R8 event and ack on same cycle
        bus_wr = 1; bus_sel = 0; bus_wdata = 8'h20; eng_eof = 2'b10; tick(); idle();
        peek(1, "R8 flag survives same-cycle ack", 8'h80);
        wr_ctrl(8'h20);
        peek(1, "R4 ch1 ack clears", 8'h00);

        // R7 live status patterns
        for (int i = 0; i < 40; i++) begin
            eng_busy = NUM_CH'($urandom); eng_src_rdy = NUM_CH'($urandom);
            eng_dst_rdy = NUM_CH'($urandom); bus_sel = 1;
            tick();
        end

        // randomized mix compared every clock
        for (int i = 0; i < 400; i++) begin
            bus_wr = 1'($urandom); bus_sel = 1'($urandom); bus_wdata = DW'($urandom);
            eng_eof = NUM_CH'($urandom) & NUM_CH'($urandom);
            eng_busy = NUM_CH'($urandom); eng_src_rdy = NUM_CH'($urandom);
            eng_dst_rdy = NUM_CH'($urandom);
            tick();
        end
        idle();
        tick();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule